// File: doc/BRIEF.md
# Priority-then-Round-Robin Grant Sequencer

This block ranks the requests that compete for one delay-line contention stage during a single slot. Up to `N` (16 by default) inputs each present a valid flag and a small priority value taken from their packet header. A one-cycle `start` pulse captures all of them at once. The block then issues one grant per clock cycle. It always picks the highest remaining priority. Among requests of equal priority it picks the first one at or after a rotating round-robin pointer. Each grant is shown as a one-hot vector and as an index, and it is also appended to an ordered list. When the slot is complete, `done` rises and the list and the grant count are valid. A downstream delay-line allocator can use the per-step grants or the finished list.

One instance serves one contention stage, and a plane places one instance next to each stage so that all stages are ranked in parallel. The round-robin pointer persists from slot to slot. Because of this, inputs that share a priority level take turns being first, and none of them is starved.

The control is a three-state machine:
- `ST_IDLE` waits for `start`, then captures the request set (transition *capture*).
- `ST_SCAN` grants one request per cycle while any remain (transition *grant*). Once none remain it leaves (transition *drain*).
- `ST_FINISH` presents `done`, commits the new pointer and returns to idle (transition *commit*).

Top module: `tray_grant_sequencer`

## Requirements
- R1: A `start` pulse seen while `busy` is low captures `req_valid` and `req_prio`, and `busy` is high from the next cycle until the cycle after `done`. A `start` seen while `busy` is high is ignored and does not alter the ongoing slot's grants or list.
- R2: In each cycle, `grant_strobe` marks at most one grant. When it is high, `grant_onehot` has exactly the bit `grant_idx` set. Only inputs that were valid at capture are granted, and each is granted at most once per slot.
- R3: Every captured valid request is granted. With k valid requests, the strobes appear in the 1st to the k-th cycle after the capturing edge, and `done` is high in cycle k+1 with `grant_count` equal to k.
- R4: The priority of input i is `req_prio[i*3 +: 3]` (3 bits, larger value means more urgent). Grants within a slot come in non-increasing priority order.
- R5: Requests of equal priority are granted in ascending cyclic index order, starting at the current value of `rr_ptr` and wrapping from N-1 to 0.
- R6: After a slot with at least one grant, `rr_ptr` equals one past the last index granted at the slot's highest priority level (N-1 wraps to 0). The new value is visible the cycle after `done`.
- R7: A slot with no valid request gives no strobe, shows `done` in the first cycle after capture with `grant_count` 0, and leaves `rr_ptr` unchanged.
- R8: After reset, `busy`, `done`, `grant_strobe`, `grant_count` and `rr_ptr` are all zero.
- R9: From `done` until the next capture, list entry j (`order_list[j*4 +: 4]`) holds the j-th granted index. Entries at or beyond `grant_count` are zero.
- R10: An input whose priority is fixed above another's is granted ahead of it in every slot, whatever the pointer is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture the request set for a new slot |
| req_valid | input | N | One request flag per input |
| req_prio | input | N*PW | Packed priority values, input i at bits i*PW |
| busy | output | 1 | Slot being processed |
| grant_strobe | output | 1 | A grant is presented this cycle |
| grant_onehot | output | N | One-hot form of the current grant |
| grant_idx | output | IW | Index of the current grant |
| done | output | 1 | Slot finished; list and count valid |
| grant_count | output | CW | Number of grants in the slot |
| order_list | output | N*IW | Packed ordered grant list |
| rr_ptr | output | IW | Round-robin start position for the next slot |

## Verification
The capturing edge is cycle 0. A slot with k valid requests shows its j-th grant strobe in cycle j, shows `done` and the final count and list in cycle k+1, and shows the committed pointer in cycle k+2. The bench drives inputs on falling edges and counts falling edges after the capture. It records each strobe together with its cycle number and requires `done` at exactly cycle k+1. It reads the pointer one falling edge after `done`. Expected orders and pointer values come from a bench model of the ranking rules, so a slot whose grants arrive early, late or in another order is reported against the cycle and position where it was due.

// File: rtl/gs_pkg.sv
package gs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_FINISH = 2'd2
    } gs_state_t;
endpackage

// File: rtl/gs_max_prio.sv
// Finds the highest priority among pending requests and flags the
// requests that sit at that level.
module gs_max_prio #(
    parameter int N  = 16,
    parameter int PW = 3
) (
    input  logic [N-1:0]    pending,
    input  logic [N*PW-1:0] prio,
    output logic [PW-1:0]   max_prio,
    output logic [N-1:0]    at_max
);
    always_comb begin
        max_prio = '0;
        for (int i = 0; i < N; i++) begin
            if (pending[i] && (prio[i*PW +: PW] > max_prio)) begin
                max_prio = prio[i*PW +: PW];
            end
        end
    end

    generate
        for (genvar g = 0; g < N; g++) begin : g_cand
            assign at_max[g] = pending[g] && (prio[g*PW +: PW] == max_prio);
        end
    endgenerate
endmodule

// File: rtl/gs_rr_pick.sv
// Picks the first candidate at or after the pointer, cyclically.
module gs_rr_pick #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  cand,
    input  logic [IW-1:0] ptr,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot
);
    always_comb begin
        any    = 1'b0;
        idx    = '0;
        onehot = '0;
        for (int i = 0; i < N; i++) begin
            int j;
            j = int'(ptr) + i;
            if (j >= N) begin
                j = j - N;
            end
            if (!any && cand[j]) begin
                any       = 1'b1;
                idx       = IW'(j);
                onehot[j] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/gs_order_list.sv
// Storage for the ordered grant list of one slot.
module gs_order_list #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_pos,
    input  logic [IW-1:0] wr_data,
    output logic [N*IW-1:0] list_flat
);
    generate
        for (genvar g = 0; g < N; g++) begin : g_slot
            logic [IW-1:0] entry_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    entry_q <= '0;
                end else if (clear) begin
                    entry_q <= '0;
                end else if (wr_en && (wr_pos == IW'(g))) begin
                    entry_q <= wr_data;
                end
            end
            assign list_flat[g*IW +: IW] = entry_q;
        end
    endgenerate
endmodule

// File: rtl/tray_grant_sequencer.sv
module tray_grant_sequencer #(
    parameter int N  = 16,
    parameter int PW = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1,
    localparam int CW = $clog2(N + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [N-1:0]    req_valid,
    input  logic [N*PW-1:0] req_prio,
    output logic            busy,
    output logic            grant_strobe,
    output logic [N-1:0]    grant_onehot,
    output logic [IW-1:0]   grant_idx,
    output logic            done,
    output logic [CW-1:0]   grant_count,
    output logic [N*IW-1:0] order_list,
    output logic [IW-1:0]   rr_ptr
);
    import gs_pkg::*;

    gs_state_t state_q, state_d;

    logic [N-1:0]    pending_q;
    logic [N*PW-1:0] prio_q;
    logic [PW-1:0]   top_prio_q;
    logic [IW-1:0]   last_top_q;
    logic [IW-1:0]   ptr_q;
    logic [CW-1:0]   count_q;
    logic            strobe_q;
    logic [N-1:0]    onehot_q;
    logic [IW-1:0]   idx_q;

    logic [PW-1:0]   level;
    logic [N-1:0]    at_level;
    logic            pick_any;
    logic [IW-1:0]   pick_idx;
    logic [N-1:0]    pick_oh;

    gs_max_prio #(.N(N), .PW(PW)) u_max (
        .pending  (pending_q),
        .prio     (prio_q),
        .max_prio (level),
        .at_max   (at_level)
    );

    gs_rr_pick #(.N(N), .IW(IW)) u_pick (
        .cand   (at_level),
        .ptr    (ptr_q),
        .any    (pick_any),
        .idx    (pick_idx),
        .onehot (pick_oh)
    );

    logic capture;
    logic grant_now;
    assign capture   = (state_q == ST_IDLE) && start;
    assign grant_now = (state_q == ST_SCAN) && pick_any;

    gs_order_list #(.N(N), .IW(IW)) u_list (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (capture),
        .wr_en     (grant_now),
        .wr_pos    (count_q[IW-1:0]),
        .wr_data   (pick_idx),
        .list_flat (order_list)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SCAN;
            ST_SCAN:   if (!pick_any) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q  <= '0;
            prio_q     <= '0;
            top_prio_q <= '0;
            last_top_q <= '0;
            ptr_q      <= '0;
            count_q    <= '0;
            strobe_q   <= 1'b0;
            onehot_q   <= '0;
            idx_q      <= '0;
        end else begin
            strobe_q <= 1'b0;
            onehot_q <= '0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        pending_q <= req_valid;
                        prio_q    <= req_prio;
                        count_q   <= '0;
                    end
                end
                ST_SCAN: begin
                    if (pick_any) begin
                        pending_q <= pending_q & ~pick_oh;
                        strobe_q  <= 1'b1;
                        onehot_q  <= pick_oh;
                        idx_q     <= pick_idx;
                        count_q   <= count_q + CW'(1);
                        if (count_q == '0) begin
                            top_prio_q <= level;
                            last_top_q <= pick_idx;
                        end else if (level == top_prio_q) begin
                            last_top_q <= pick_idx;
                        end
                    end
                end
                ST_FINISH: begin
                    if (count_q != '0) begin
                        ptr_q <= (last_top_q == IW'(N - 1)) ? '0
                                                            : last_top_q + IW'(1);
                    end
                end
                default: begin
                    pending_q <= '0;
                end
            endcase
        end
    end

    assign busy         = (state_q != ST_IDLE);
    assign done         = (state_q == ST_FINISH);
    assign grant_strobe = strobe_q;
    assign grant_onehot = onehot_q;
    assign grant_idx    = idx_q;
    assign grant_count  = count_q;
    assign rr_ptr       = ptr_q;
endmodule

// File: rtl/gs_checker.sv
module gs_checker #(
    parameter int N  = 16,
    parameter int PW = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1,
    localparam int CW = $clog2(N + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [N-1:0]    req_valid,
    input logic [N*PW-1:0] req_prio,
    input logic            busy,
    input logic            grant_strobe,
    input logic [N-1:0]    grant_onehot,
    input logic [IW-1:0]   grant_idx,
    input logic            done,
    input logic [CW-1:0]   grant_count,
    input logic [N*IW-1:0] order_list,
    input logic [IW-1:0]   rr_ptr
);
    logic [N-1:0]    cap_valid;
    logic [N*PW-1:0] cap_prio;
    logic [N-1:0]    served;
    logic [PW-1:0]   prev_prio;
    logic            any_granted;
    logic [PW-1:0]   gp;

    assign gp = cap_prio[grant_idx*PW +: PW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_valid   <= '0;
            cap_prio    <= '0;
            served      <= '0;
            prev_prio   <= '0;
            any_granted <= 1'b0;
        end else if (start && !busy) begin
            cap_valid   <= req_valid;
            cap_prio    <= req_prio;
            served      <= '0;
            any_granted <= 1'b0;
        end else if (grant_strobe) begin
            served[grant_idx] <= 1'b1;
            prev_prio         <= gp;
            any_granted       <= 1'b1;
        end
    end

    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        grant_strobe |-> ($countones(grant_onehot) == 1) && grant_onehot[grant_idx]);

    a_r2_valid_once: assert property (@(posedge clk) disable iff (!rst_n)
        grant_strobe |-> cap_valid[grant_idx] && !served[grant_idx]);

    a_r4_prio_order: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_strobe && any_granted) |-> (gp <= prev_prio));

    a_r3_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (grant_count == CW'($countones(cap_valid))));

    a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (grant_count == '0)) |=> $stable(rr_ptr));

    a_r1_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_strobe || done) |-> busy);

    a_r2_no_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_strobe |-> (grant_onehot == '0));
endmodule

bind tray_grant_sequencer gs_checker #(.N(N), .PW(PW)) u_gs_checker (.*);

// File: tb/test_tray_grant_sequencer.sv
module test_tray_grant_sequencer;
    localparam int N  = 16;
    localparam int PW = 3;
    localparam int IW = 4;
    localparam int CW = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [N-1:0]    req_valid = '0;
    logic [N*PW-1:0] req_prio = '0;
    logic            busy, grant_strobe, done;
    logic [N-1:0]    grant_onehot;
    logic [IW-1:0]   grant_idx, rr_ptr;
    logic [CW-1:0]   grant_count;
    logic [N*IW-1:0] order_list;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int mptr = 0;

    always #2 clk = ~clk;

    tray_grant_sequencer #(.N(N), .PW(PW)) i_tray_grant_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid),
        .req_prio(req_prio), .busy(busy), .grant_strobe(grant_strobe),
        .grant_onehot(grant_onehot), .grant_idx(grant_idx), .done(done),
        .grant_count(grant_count), .order_list(order_list), .rr_ptr(rr_ptr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Runs one slot, checks grants, timing, list, count and pointer.
    // Returns the first granted index (or -1).
    task automatic run_slot(input logic [N-1:0] v, input logic [N*PW-1:0] p,
                            input string req, input bit poke, output int first);
        int exp_ord[N];
        int k = 0;
        int got[N];
        int gcnt = 0;
        int cyc = 0;
        int done_cyc = -1;
        logic [N-1:0] rem = v;
        int top = -1;
        int last_top = 0;
        // expected order from the ranking rules
        while (rem != '0) begin
            int mx = -1;
            int pick = -1;
            for (int i = 0; i < N; i++)
                if (rem[i] && int'(p[i*PW +: PW]) > mx) mx = int'(p[i*PW +: PW]);
            for (int s = 0; s < N; s++) begin
                int j = (mptr + s) % N;
                if (pick < 0 && rem[j] && int'(p[j*PW +: PW]) == mx) pick = j;
            end
            if (top < 0) top = mx;
            if (mx == top) last_top = pick;
            exp_ord[k] = pick;
            k++;
            rem[pick] = 1'b0;
        end
        @(negedge clk);
        start = 1'b1; req_valid = v; req_prio = p;
        @(negedge clk);
        start = 1'b0; req_valid = '0; req_prio = '0;
        chk(busy === 1'b1, "R1", "busy after capture", int'(busy), 1);
        while (done_cyc < 0 && cyc < 40) begin
            if (poke && cyc == 1) begin
                start = 1'b1; req_valid = '1; req_prio = '1;
            end else begin
                start = 1'b0; req_valid = '0; req_prio = '0;
            end
            @(negedge clk);
            cyc++;
            if (grant_strobe) begin
                chk(grant_onehot == (N'(1) << grant_idx), "R2", "onehot vs index",
                    int'(grant_onehot), 1 << grant_idx);
                chk(cyc == gcnt + 1, "R3", "strobe cycle", cyc, gcnt + 1);
                if (gcnt < N) got[gcnt] = int'(grant_idx);
                gcnt++;
            end
            if (done) done_cyc = cyc;
        end
        start = 1'b0; req_valid = '0; req_prio = '0;
        chk(gcnt == k, "R3", "grant total", gcnt, k);
        chk(done_cyc == k + 1, "R3", "done cycle", done_cyc, k + 1);
        chk(int'(grant_count) == k, "R3", "grant_count", int'(grant_count), k);
        if (k == 0) chk(gcnt == 0, "R7", "strobes in empty slot", gcnt, 0);
        for (int j = 0; j < k && j < gcnt; j++)
            chk(got[j] == exp_ord[j], req, $sformatf("grant %0d", j), got[j], exp_ord[j]);
        for (int j = 0; j < N; j++) begin
            int e = (j < k) ? exp_ord[j] : 0;
            int a = int'(order_list[j*IW +: IW]);
            chk(a == e, "R9", $sformatf("list entry %0d", j), a, e);
        end
        if (k > 0) mptr = (last_top + 1) % N;
        @(negedge clk);
        chk(int'(rr_ptr) == mptr, (k > 0) ? "R6" : "R7", "rr_ptr", int'(rr_ptr), mptr);
        chk(busy === 1'b0, "R1", "busy after slot", int'(busy), 0);
        first = (gcnt > 0) ? got[0] : -1;
    endtask

    function automatic logic [N*PW-1:0] flat_prio(input int sel);
        logic [N*PW-1:0] r = '0;
        for (int i = 0; i < N; i++) begin
            case (sel)
                0: r[i*PW +: PW] = 3'd4;
                1: r[i*PW +: PW] = PW'(i % 8);
                default: r[i*PW +: PW] = PW'((i * 5) % 8);
            endcase
        end
        return r;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && grant_strobe === 1'b0, "R8",
            "flags in reset", int'({busy, done, grant_strobe}), 0);
        chk(rr_ptr === '0 && grant_count === '0, "R8", "ptr/count in reset",
            int'(rr_ptr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0, "R8", "idle after reset", int'(busy), 0);
        mptr = 0;
    endtask

    task automatic t_equal_full();
        int f;
        run_slot('1, flat_prio(0), "R5", 1'b0, f);      // wraps pointer to 0 (R6)
    endtask

    task automatic t_equal_rotate();
        int f;
        run_slot(16'h1088, flat_prio(0), "R5", 1'b0, f); // 3,7,12 -> ptr 13
        run_slot(16'h4022, flat_prio(0), "R5", 1'b0, f); // 14,1,5 rotation
    endtask

    task automatic t_mixed();
        int f;
        run_slot('1, flat_prio(1), "R4", 1'b0, f);
        run_slot(16'hB5A3, flat_prio(2), "R4", 1'b0, f);
    endtask

    task automatic t_empty();
        int f;
        run_slot('0, flat_prio(0), "R7", 1'b0, f);
    endtask

    task automatic t_busy_start();
        int f;
        run_slot(16'h0611, flat_prio(2), "R1", 1'b1, f);
    endtask

    task automatic t_fixed_prio();
        logic [N*PW-1:0] p = '0;
        logic [N-1:0] v = '0;
        int f;
        v[2] = 1'b1; v[5] = 1'b1; v[9] = 1'b1;
        p[2*PW +: PW] = 3'd7;
        p[5*PW +: PW] = 3'd3;
        p[9*PW +: PW] = 3'd3;
        for (int r = 0; r < 3; r++) begin
            run_slot(v, p, "R10", 1'b0, f);
            chk(f == 2, "R10", "fixed-high input first", f, 2);
        end
    endtask

    task automatic t_top_level_ptr();
        logic [N*PW-1:0] p = '0;
        int f;
        p[2*PW +: PW] = 3'd5;
        p[9*PW +: PW] = 3'd1;
        p[10*PW +: PW] = 3'd5;
        run_slot(16'h0604, p, "R6", 1'b0, f);
        run_slot(16'h8000, '0, "R6", 1'b0, f);           // single at 15 -> ptr 0
    endtask

    initial begin
        t_reset();
        t_equal_full();
        t_equal_rotate();
        t_mixed();
        t_empty();
        t_busy_start();
        t_fixed_prio();
        t_top_level_ptr();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule